// File: doc/BRIEF.md
# Register-Mapped DAC Update Controller

This block is the digital front end of a 12-bit voltage DAC. It has a small bus slave with two registers. The first is a 16-bit control word that selects the output span, the buffer options, power-down, the update source and interpolation. The second is a 32-bit data word that carries a 12-bit converter code and four extra fractional bits. A data write only loads a pending (holding) value. The code reaches the converter when the selected update strobe occurs: every system clock cycle, or a falling edge on an external timer tick. The timer source lets software queue the next waveform sample ahead of each tick.

A clear bit in the control word, active low, zeroes both the pending value and the converter code in the cycle it is written, whatever the strobe does. In interpolation mode, a first-order error-feedback modulator adds the four fractional bits to a residue on every divided-clock enable. Each carry raises the code by one step, so the average output takes a 16-bit resolution. The divider is 16 or 32 input clocks. The outputs are the code, the span select, the buffer controls and an output enable.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0200, the data word reads 0, `dac_oe` is 0 and `dac_code` is 0.
- R2: Control word fields: bits 1:0 span (`dac_range`), bit 2 fast modulator rate, bit 3 interpolation, bit 4 clear (active low), bit 5 update source (1 = clock), bit 6 buffer bypass, bit 7 op-amp mode, bit 8 buffer low power, bit 9 power-down (`dac_oe` = not bit 9). Bits 15:10 read 0. The outputs follow one cycle after the write.
- R3: The data word at offset 0x604 keeps the code in bits 27:16 and the fraction in bits 15:12. Bits 31:28 and 11:0 read 0. The control word sits at offset 0x600.
- R4: With bit 5 = 1, the pending value reaches `dac_code` on the clock edge after the one that stored it.
- R5: With bit 5 = 0, `dac_code` changes only on the clock edge where `timer_tick` is sampled low after being sampled high. Rising edges and data writes alone leave it unchanged.
- R6: A control write with bit 4 = 0 zeroes `dac_code` and the stored data at that edge, taking precedence over a same-cycle timer strobe. While bit 4 stays 0, data writes are ignored.
- R7: With interpolation off, `dac_code` equals the 12-bit code and the fraction has no effect.
- R8: With interpolation on, every modulator period lasts 16 clocks (bit 2 = 1) or 32 clocks (bit 2 = 0). Over any 16 consecutive periods, exactly `frac` of them show code+1 and the rest show the code.
- R9: The interpolated code saturates at 0xFFF.
- R10: While powered down, `dac_oe` is 0, the modulator is held reset (`dac_code` equals the plain code), and both registers keep their contents.
- R11: Writes to unmapped offsets change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from offset) |
| timer_tick | input | 1 | Update tick; the falling edge is the strobe in timer mode |
| dac_code | output | 12 | Code to the converter |
| dac_range | output | 2 | Output span select |
| dac_oe | output | 1 | Output enable (low = tristated) |
| buf_lowpwr | output | 1 | Output buffer low-power control |
| opamp_en | output | 1 | Buffer used as op amp |
| buf_bypass | output | 1 | Output buffer bypassed |

## Verification
The hardest case to reach is the clear racing the strobe. A control write with the clear bit low must land on the same edge where a timer falling edge is detected, while a non-zero value is pending. The bench does this by raising the tick one cycle early. It then drops the tick and presents the control write at the same falling clock edge. The interpolation averages also depend on long, steady windows. The bench lets the modulator settle and then counts the cycles and code transitions at code+1 over exactly 16 periods. The count comes out the same wherever the window starts, because the carry pattern repeats every 16 periods.

// File: rtl/dac_pkg.sv
// Package: shared types and register offsets for the DAC update controller.
// Assumes a 16-bit control word with reserved bits held at zero.
package dac_pkg;

    typedef struct packed {
        logic [5:0] rsvd;
        logic       pd;
        logic       buf_lp;
        logic       opamp;
        logic       bypass;
        logic       upd_clk;
        logic       clr_n;
        logic       interp;
        logic       rate_fast;
        logic [1:0] range;
    } dac_ctrl_t;

    localparam logic [15:0] CTRL_RESET = 16'h0200;
    localparam logic [11:0] CTRL_OFS   = 12'h600;
    localparam logic [11:0] DATA_OFS   = 12'h604;

endpackage

// File: rtl/dac_ctrl_regs.sv
// Control register and write decode.
// Holds the control word and decodes bus writes for both registers.
// Derives the effective clear, so that a write with clear low acts in its own cycle.
// Assumes single-cycle bus accesses qualified by bus_sel.
module dac_ctrl_regs
    import dac_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [9:0]        ctrl_wdata,
    output dac_ctrl_t         ctrl,
    output logic              data_wr,
    output logic              clr_now
);

    logic ctrl_wr;

    // Decode writes to the two mapped offsets.
    always_comb begin
        ctrl_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
        data_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(DATA_OFS));
    end

    // Control word storage; reserved bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= dac_ctrl_t'(CTRL_RESET);
        end else if (ctrl_wr) begin
            ctrl <= dac_ctrl_t'({6'b0, ctrl_wdata});
        end
    end

    // The clear value being written takes effect immediately.
    always_comb begin
        clr_now = ctrl_wr ? !ctrl_wdata[4] : !ctrl.clr_n;
    end

endmodule

// File: rtl/dac_code_path.sv
// Holding and active code registers.
// Data writes load the holding register. The selected strobe (every clock,
// or a falling edge of the timer tick seen between two samples) copies it
// into the active register. Clear zeroes both and wins over everything.
// Assumes timer_tick is already synchronous to clk.
module dac_code_path #(
    parameter int CODE_W = 12,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [FRAC_W-1:0] wr_frac,
    input  logic              clr_now,
    input  logic              upd_clk,
    input  logic              timer_tick,
    output logic [CODE_W-1:0] hold_code,
    output logic [FRAC_W-1:0] hold_frac,
    output logic [CODE_W-1:0] act_code,
    output logic [FRAC_W-1:0] act_frac,
    output logic              tick_fall
);

    logic tick_prev;
    logic strobe;

    // Previous tick sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_prev <= 1'b0;
        else        tick_prev <= timer_tick;
    end

    // Falling-edge detect and selection of the update strobe.
    always_comb begin
        tick_fall = tick_prev && !timer_tick;
        strobe    = upd_clk || tick_fall;
    end

    // Holding and active registers with clear precedence.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_now) begin
            hold_code <= '0;
            hold_frac <= '0;
            act_code  <= '0;
            act_frac  <= '0;
        end else begin
            if (data_wr) begin
                hold_code <= wr_code;
                hold_frac <= wr_frac;
            end
            if (strobe) begin
                act_code <= hold_code;
                act_frac <= hold_frac;
            end
        end
    end

endmodule

// File: rtl/dac_interp.sv
// First-order error-feedback interpolator.
// On every divided-clock enable, the fraction is added to a residue. The carry
// lifts the output code by one step until the next enable, saturating at
// full scale. Divider and modulator are held at zero while run is low.
// Assumes DIV_SLOW >= DIV_FAST >= 2.
module dac_interp #(
    parameter int CODE_W   = 12,
    parameter int FRAC_W   = 4,
    parameter int DIV_FAST = 16,
    parameter int DIV_SLOW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rate_fast,
    input  logic [CODE_W-1:0] act_code,
    input  logic [FRAC_W-1:0] act_frac,
    output logic [CODE_W-1:0] code_out
);

    localparam int CNT_W = $clog2(DIV_SLOW);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [CNT_W-1:0]  div_cnt;
    logic [CNT_W-1:0]  div_last;
    logic              mod_en;
    logic [FRAC_W-1:0] residue;
    logic [FRAC_W:0]   mod_sum;
    logic              carry;

    // Terminal count for the selected modulator rate.
    always_comb begin
        div_last = rate_fast ? CNT_W'(DIV_FAST - 1) : CNT_W'(DIV_SLOW - 1);
        mod_en   = run && (div_cnt >= div_last);
        mod_sum  = {1'b0, residue} + {1'b0, act_frac};
    end

    // Clock divider producing the modulator enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  div_cnt <= '0;
        else if (mod_en)     div_cnt <= '0;
        else                 div_cnt <= div_cnt + 1'b1;
    end

    // Residue accumulator and registered carry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            residue <= '0;
            carry   <= 1'b0;
        end else if (mod_en) begin
            residue <= mod_sum[FRAC_W-1:0];
            carry   <= mod_sum[FRAC_W];
        end
    end

    // Saturating one-step increment of the active code.
    always_comb begin
        if (carry && (act_code != CODE_MAX)) code_out = act_code + 1'b1;
        else                                 code_out = act_code;
    end

endmodule

// File: rtl/dac_update_ctrl.sv
// Top of the DAC update controller.
// Joins the control register, the code path and the interpolator, and
// multiplexes register reads. The interpolator runs only with interpolation
// set, power-down clear and no clear in progress.
// Assumes a single-master bus with combinational reads.
module dac_update_ctrl
    import dac_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int CODE_W   = 12,
    parameter int FRAC_W   = 4,
    parameter int DIV_FAST = 16,
    parameter int DIV_SLOW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              timer_tick,
    output logic [CODE_W-1:0] dac_code,
    output logic [1:0]        dac_range,
    output logic              dac_oe,
    output logic              buf_lowpwr,
    output logic              opamp_en,
    output logic              buf_bypass
);

    localparam int CODE_LSB = 16;
    localparam int FRAC_LSB = CODE_LSB - FRAC_W;

    dac_ctrl_t         ctrl;
    logic              data_wr;
    logic              clr_now;
    logic              upd_clk_sel;
    logic              tick_fall;
    logic              interp_run;
    logic [CODE_W-1:0] hold_code;
    logic [FRAC_W-1:0] hold_frac;
    logic [CODE_W-1:0] act_code;
    logic [FRAC_W-1:0] act_frac;

    dac_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .ctrl_wdata (bus_wdata[9:0]),
        .ctrl       (ctrl),
        .data_wr    (data_wr),
        .clr_now    (clr_now)
    );

    dac_code_path #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_wr    (data_wr),
        .wr_code    (bus_wdata[CODE_LSB +: CODE_W]),
        .wr_frac    (bus_wdata[FRAC_LSB +: FRAC_W]),
        .clr_now    (clr_now),
        .upd_clk    (upd_clk_sel),
        .timer_tick (timer_tick),
        .hold_code  (hold_code),
        .hold_frac  (hold_frac),
        .act_code   (act_code),
        .act_frac   (act_frac),
        .tick_fall  (tick_fall)
    );

    dac_interp #(
        .CODE_W   (CODE_W),
        .FRAC_W   (FRAC_W),
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_interp (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (interp_run),
        .rate_fast (ctrl.rate_fast),
        .act_code  (act_code),
        .act_frac  (act_frac),
        .code_out  (dac_code)
    );

    // Mode qualifiers and direct control outputs.
    always_comb begin
        upd_clk_sel = ctrl.upd_clk;
        interp_run  = ctrl.interp && !ctrl.pd && !clr_now;
        dac_range   = ctrl.range;
        dac_oe      = !ctrl.pd;
        buf_lowpwr  = ctrl.buf_lp;
        opamp_en    = ctrl.opamp;
        buf_bypass  = ctrl.bypass;
    end

    // Read multiplexer; unmapped offsets and reserved bits return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_OFS)) begin
            bus_rdata[15:0] = ctrl;
        end else if (bus_addr == ADDR_W'(DATA_OFS)) begin
            bus_rdata[CODE_LSB +: CODE_W] = hold_code;
            bus_rdata[FRAC_LSB +: FRAC_W] = hold_frac;
        end
    end

endmodule

// File: rtl/dac_update_ctrl_chk.sv
// Checker for the DAC update controller, bound into the top.
// Relates bus writes, strobes and internal code registers to the outputs.
module dac_update_ctrl_chk
    import dac_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [CODE_W-1:0] dac_code,
    input logic              dac_oe,
    input logic [CODE_W-1:0] act_code,
    input logic [CODE_W-1:0] hold_code,
    input logic              upd_clk_sel,
    input logic              tick_fall,
    input logic              clr_now
);

    // R2: the output enable follows the power-down bit that was just written.
    p_oe_follows_pd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_W'(CTRL_OFS)) |=> (dac_oe == !$past(bus_wdata[9])));

    // R4: in clock update mode, the active code takes the previous pending value.
    p_clk_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_clk_sel && !clr_now) |=> (act_code == $past(hold_code)));

    // R5: in timer mode, with no falling edge, the active code holds.
    p_timer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_clk_sel && !tick_fall && !clr_now) |=> $stable(act_code));

    // R6: a clear yields a zero code on the next cycle.
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> (dac_code == '0));

    // R8: the interpolated code is never more than one step above the active code.
    p_step_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code == act_code) || ({1'b0, dac_code} == ({1'b0, act_code} + 1'b1)));

    // R10: while powered down, the modulator adds nothing.
    p_pd_plain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_oe |=> (dac_code == act_code));

endmodule

bind dac_update_ctrl dac_update_ctrl_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .dac_code    (dac_code),
    .dac_oe      (dac_oe),
    .act_code    (act_code),
    .hold_code   (hold_code),
    .upd_clk_sel (upd_clk_sel),
    .tick_fall   (tick_fall),
    .clr_now     (clr_now)
);

// File: tb/dac_update_ctrl_bench.sv
// Directed bench for the DAC update controller: one task per scenario.
module dac_update_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        timer_tick = 1'b0;
    logic [11:0] dac_code;
    logic [1:0]  dac_range;
    logic        dac_oe;
    logic        buf_lowpwr;
    logic        opamp_en;
    logic        buf_bypass;

    int checks = 0;
    int failures = 0;

    localparam logic [11:0] A_CTRL = 12'h600;
    localparam logic [11:0] A_DATA = 12'h604;

    always #2 clk = ~clk;

    dac_update_ctrl u_dac_update_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .timer_tick (timer_tick),
        .dac_code   (dac_code),
        .dac_range  (dac_range),
        .dac_oe     (dac_oe),
        .buf_lowpwr (buf_lowpwr),
        .opamp_en   (opamp_en),
        .buf_bypass (buf_bypass)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        bus_read(A_CTRL, r); check("R1 ctrl reset", r, 32'h0200);
        bus_read(A_DATA, r); check("R1 data reset", r, 32'h0);
        check("R1 oe reset", {31'b0, dac_oe}, 32'h0);
        check("R1 code reset", {20'b0, dac_code}, 32'h0);
    endtask

    task automatic t_ctrl_fields();
        logic [31:0] r;
        bus_write(A_CTRL, 32'h0000_FDF3);
        bus_read(A_CTRL, r); check("R2 reserved bits read zero", r, 32'h01F3);
        check("R2 range", {30'b0, dac_range}, 32'h3);
        check("R2 buffer flags", {29'b0, buf_lowpwr, opamp_en, buf_bypass}, 32'h7);
        check("R2 oe on", {31'b0, dac_oe}, 32'h1);
        bus_write(A_CTRL, 32'h0000_0231);
        check("R2 oe off", {31'b0, dac_oe}, 32'h0);
        check("R2 range 01", {30'b0, dac_range}, 32'h1);
        check("R2 flags off", {29'b0, buf_lowpwr, opamp_en, buf_bypass}, 32'h0);
    endtask

    task automatic t_clock_mode();
        logic [31:0] r;
        bus_write(A_CTRL, 32'h0030);
        bus_write(A_DATA, 32'hFABC_5FFF);
        check("R4 code not yet moved", {20'b0, dac_code}, 32'h0);
        cycles(1);
        check("R4 code after one edge", {20'b0, dac_code}, 32'hABC);
        bus_read(A_DATA, r); check("R3 data field layout", r, 32'h0ABC_5000);
    endtask

    task automatic t_timer_mode();
        bus_write(A_CTRL, 32'h0010);
        bus_write(A_DATA, 32'h0123_0000);
        cycles(5);
        check("R5 write alone holds code", {20'b0, dac_code}, 32'hABC);
        timer_tick = 1'b1;
        cycles(2);
        check("R5 rising tick holds code", {20'b0, dac_code}, 32'hABC);
        timer_tick = 1'b0;
        cycles(1);
        check("R5 falling tick updates", {20'b0, dac_code}, 32'h123);
        bus_write(A_DATA, 32'h0456_0000);
        cycles(4);
        check("R5 no edge holds code", {20'b0, dac_code}, 32'h123);
    endtask

    task automatic t_clear();
        logic [31:0] r;
        timer_tick = 1'b1;
        cycles(1);
        timer_tick = 1'b0;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h0000;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check("R6 clear beats same-cycle strobe", {20'b0, dac_code}, 32'h0);
        bus_read(A_DATA, r); check("R6 stored data cleared", r, 32'h0);
        bus_write(A_DATA, 32'h0777_0000);
        bus_read(A_DATA, r); check("R6 write ignored while clear", r, 32'h0);
        timer_tick = 1'b1; cycles(1); timer_tick = 1'b0; cycles(2);
        check("R6 code stays zero while clear", {20'b0, dac_code}, 32'h0);
    endtask

    task automatic t_interp_off();
        int bad = 0;
        bus_write(A_CTRL, 32'h0030);
        bus_write(A_DATA, 32'h0100_F000);
        cycles(2);
        for (int i = 0; i < 64; i++) begin
            if (dac_code !== 12'h100) bad++;
            cycles(1);
        end
        check("R7 fraction ignored with interpolation off", bad, 0);
    endtask

    task automatic t_interp(input logic fast, input logic [3:0] frac, input logic [11:0] code,
                            input int exp_tr);
        int win = fast ? 256 : 512;
        int hi = 0, other = 0, tr = 0;
        logic [11:0] prev;
        bus_write(A_CTRL, fast ? 32'h003C : 32'h0038);
        bus_write(A_DATA, {4'b0, code, frac, 12'b0});
        cycles(80);
        prev = dac_code;
        for (int i = 0; i < win; i++) begin
            cycles(1);
            if (dac_code == code + 12'd1) hi++;
            else if (dac_code != code) other++;
            if (dac_code != prev) tr++;
            prev = dac_code;
        end
        check("R8 cycles at code+1 over 16 periods", hi, frac * (win / 16));
        check("R8 only code or code+1", other, 0);
        if (exp_tr >= 0) check("R8 transitions match period length", tr, exp_tr);
    endtask

    task automatic t_sat();
        int bad = 0;
        bus_write(A_CTRL, 32'h003C);
        bus_write(A_DATA, 32'h0FFF_F000);
        cycles(80);
        for (int i = 0; i < 64; i++) begin
            if (dac_code !== 12'hFFF) bad++;
            cycles(1);
        end
        check("R9 saturates at full scale", bad, 0);
    endtask

    task automatic t_pd();
        logic [31:0] r;
        int bad = 0, hi = 0;
        bus_write(A_CTRL, 32'h023C);
        bus_write(A_DATA, 32'h0100_F000);
        cycles(3);
        check("R10 oe low in power-down", {31'b0, dac_oe}, 32'h0);
        for (int i = 0; i < 128; i++) begin
            if (dac_code !== 12'h100) bad++;
            cycles(1);
        end
        check("R10 modulator held in power-down", bad, 0);
        bus_read(A_DATA, r); check("R10 data kept", r, 32'h0100_F000);
        bus_read(A_CTRL, r); check("R10 ctrl kept", r, 32'h023C);
        bus_write(A_CTRL, 32'h003C);
        cycles(80);
        for (int i = 0; i < 256; i++) begin
            cycles(1);
            if (dac_code == 12'h101) hi++;
        end
        check("R10 modulator resumes after power-up", hi, 240);
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        bus_write(12'h608, 32'hFFFF_FFFF);
        bus_read(A_CTRL, r); check("R11 ctrl untouched", r, 32'h003C);
        bus_read(A_DATA, r); check("R11 data untouched", r, 32'h0100_F000);
        bus_read(12'h608, r); check("R11 unmapped reads zero", r, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_ctrl_fields();
        t_clock_mode();
        t_timer_mode();
        t_clear();
        t_interp_off();
        t_interp(1'b1, 4'd5, 12'h200, -1);
        t_interp(1'b1, 4'd8, 12'h200, 16);
        t_interp(1'b0, 4'd8, 12'h300, 16);
        t_interp(1'b0, 4'd3, 12'h040, -1);
        t_sat();
        t_pd();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule